// File: doc/BRIEF.md
# Element-Width Polymorphic Register File

This block is an integer register file of 128 registers, 64 bits each, kept internally as one flat store of 1024 bytes. Every access names a register, a vector/scalar flag, an element width of 8, 16, 32 or 64 bits, and an element offset. The block turns these into a start byte and a byte count. Register `r` begins at byte `r*8`, and its element array runs on past that register into the registers after it. A vector element with a large offset therefore lands in a later register than the one named.

There are two combinational read ports and one write port that updates the store on the clock edge. A write changes only the bytes of the addressed element. Every other byte, including the rest of the same 64-bit register, keeps its value. A full register is replaced only by a 64-bit element at offset zero. Loops over vector length, instruction decode and predication belong to the surrounding pipeline. This block serves one element per port per cycle.

The design has no state machine. It is pure address mapping in front of a byte-write store.

Top module: `ewrf_regfile`

## Requirements
- R1: After reset is released, every byte of the store reads as zero.
- R2: When the vector flag is 0, the element offset input is ignored and treated as 0, on the read ports and on the write port.
- R3: An element of width `w` bytes at offset `k` of register `r` occupies bytes `r*8 + k*w` to `r*8 + k*w + w - 1` of the flat store, so it may lie in a register after `r`.
- R4: A write modifies only the bytes of the addressed element, and all other bytes keep their previous values (for example, byte writes to offsets 0 to 6 of a register leave its byte 7 unchanged).
- R5: A scalar 64-bit write replaces all eight bytes of the named register with `wr_data`.
- R6: Read data is the addressed element, zero-extended to 64 bits. The element byte at the lowest store address appears in bits 7:0.
- R7: If the element's last byte would lie above byte 1023, the port's out-of-range flag is 1 in that cycle, a read returns zero, and a write changes nothing.
- R8: Reads are combinational. A read of bytes that are being written in the same cycle returns the old contents, and the new contents are visible after the rising edge.
- R9: Width codes are 0 for 8 bits, 1 for 16 bits, 2 for 32 bits and 3 for 64 bits. For a write, only the low `w` bytes of `wr_data` are used.
- R10: The two read ports are independent and may address different or overlapping elements in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset that clears the store |
| rd0_reg | input | 7 | Read port 0 register number |
| rd0_vec | input | 1 | Read port 0 vector flag |
| rd0_ew | input | 2 | Read port 0 element width code |
| rd0_off | input | 10 | Read port 0 element offset |
| rd0_data | output | 64 | Read port 0 element, zero-extended |
| rd0_oor | output | 1 | Read port 0 out-of-range flag |
| rd1_reg | input | 7 | Read port 1 register number |
| rd1_vec | input | 1 | Read port 1 vector flag |
| rd1_ew | input | 2 | Read port 1 element width code |
| rd1_off | input | 10 | Read port 1 element offset |
| rd1_data | output | 64 | Read port 1 element, zero-extended |
| rd1_oor | output | 1 | Read port 1 out-of-range flag |
| wr_en | input | 1 | Write enable |
| wr_reg | input | 7 | Write register number |
| wr_vec | input | 1 | Write vector flag |
| wr_ew | input | 2 | Write element width code |
| wr_off | input | 10 | Write element offset |
| wr_data | input | 64 | Write data, low bytes used |
| wr_oor | output | 1 | Write address out-of-range flag |

## Verification
The hardest case to reach from the ports is a narrow write that lands inside a register which already holds known data in its other bytes, followed by a read that spans those bytes. Only that sequence shows whether neighbouring bytes are kept. The stimulus writes a full scalar pattern, overwrites parts of it through vector byte and halfword offsets (including offsets that spill into the next register), and then reads the whole register back. Random operations are confined to a small window of registers so that such overlaps happen often. A minority of random operations use large offsets near the top of the store to exercise the out-of-range boundary.

// File: rtl/ewrf_pkg.sv
package ewrf_pkg;

    // Element width code; the value is log2 of the element size in bytes
    typedef enum logic [1:0] {
        EW8  = 2'd0,
        EW16 = 2'd1,
        EW32 = 2'd2,
        EW64 = 2'd3
    } ew_e;

endpackage

// File: rtl/ewrf_addr_map.sv
module ewrf_addr_map
    import ewrf_pkg::*;
#(
    parameter int NUM_REGS  = 128,
    parameter int REG_BYTES = 8,
    parameter int OFF_W     = 10,
    localparam int STORE_BYTES = NUM_REGS * REG_BYTES,
    localparam int SADDR_W     = $clog2(STORE_BYTES),
    localparam int REG_W       = $clog2(NUM_REGS),
    localparam int SHIFT_W     = $clog2(REG_BYTES),
    localparam int CNT_W       = SHIFT_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [REG_W-1:0]   reg_idx,
    input  logic               is_vec,
    input  ew_e                ew,
    input  logic [OFF_W-1:0]   off,
    output logic [SADDR_W-1:0] base,
    output logic [CNT_W-1:0]   nbytes,
    output logic               oor
);

    localparam int WIDE_W = SADDR_W + OFF_W + SHIFT_W + 2;

    logic [WIDE_W-1:0] eff_off;
    logic [WIDE_W-1:0] start_w;
    logic [WIDE_W-1:0] last_w;

    always_comb begin
        eff_off = is_vec ? WIDE_W'(off) : '0;
        nbytes  = CNT_W'(1) << ew;
        start_w = (WIDE_W'(reg_idx) << SHIFT_W) + (eff_off << ew);
        last_w  = start_w + WIDE_W'(nbytes) - WIDE_W'(1);
        oor     = (last_w >= WIDE_W'(STORE_BYTES));
        base    = start_w[SADDR_W-1:0];
    end

    // R2
    scalar_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_vec |-> (!oor && base[SHIFT_W-1:0] == '0 &&
                     base[SADDR_W-1:SHIFT_W] == reg_idx));

    // R3
    elem_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oor |-> ((base & SADDR_W'(nbytes - CNT_W'(1))) == '0));

endmodule

// File: rtl/ewrf_byte_store.sv
module ewrf_byte_store #(
    parameter int NUM_REGS  = 128,
    parameter int REG_BYTES = 8,
    parameter int RD_PORTS  = 2,
    localparam int STORE_BYTES = NUM_REGS * REG_BYTES,
    localparam int SADDR_W     = $clog2(STORE_BYTES),
    localparam int CNT_W       = $clog2(REG_BYTES) + 1,
    localparam int DATA_W      = 8 * REG_BYTES
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               we,
    input  logic [SADDR_W-1:0]                 wbase,
    input  logic [CNT_W-1:0]                   wcnt,
    input  logic [DATA_W-1:0]                  wdata,
    input  logic [RD_PORTS-1:0]                rvalid,
    input  logic [RD_PORTS-1:0][SADDR_W-1:0]   rbase,
    input  logic [RD_PORTS-1:0][CNT_W-1:0]     rcnt,
    output logic [RD_PORTS-1:0][DATA_W-1:0]    rdata
);

    logic [7:0] mem [STORE_BYTES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STORE_BYTES; i++) begin
                mem[i] <= 8'h00;
            end
        end else if (we) begin
            for (int j = 0; j < REG_BYTES; j++) begin
                if (CNT_W'(j) < wcnt) begin
                    mem[wbase + SADDR_W'(j)] <= wdata[8*j +: 8];
                end
            end
        end
    end

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        always_comb begin
            for (int j = 0; j < REG_BYTES; j++) begin
                rdata[p][8*j +: 8] = (rvalid[p] && CNT_W'(j) < rcnt[p]) ?
                                     mem[rbase[p] + SADDR_W'(j)] : 8'h00;
            end
        end
    end

    // R4
    low_byte_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem[$past(wbase)] == $past(wdata[7:0]));

    // R4
    byte0_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!we || wbase != '0) |=> $stable(mem[0]));

endmodule

// File: rtl/ewrf_regfile.sv
module ewrf_regfile
    import ewrf_pkg::*;
#(
    parameter int NUM_REGS  = 128,
    parameter int REG_BYTES = 8,
    parameter int OFF_W     = 10,
    localparam int REG_W    = $clog2(NUM_REGS),
    localparam int DATA_W   = 8 * REG_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  rd0_reg,
    input  logic              rd0_vec,
    input  logic [1:0]        rd0_ew,
    input  logic [OFF_W-1:0]  rd0_off,
    output logic [DATA_W-1:0] rd0_data,
    output logic              rd0_oor,
    input  logic [REG_W-1:0]  rd1_reg,
    input  logic              rd1_vec,
    input  logic [1:0]        rd1_ew,
    input  logic [OFF_W-1:0]  rd1_off,
    output logic [DATA_W-1:0] rd1_data,
    output logic              rd1_oor,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_reg,
    input  logic              wr_vec,
    input  logic [1:0]        wr_ew,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_oor
);

    localparam int NPORT   = 3;
    localparam int RPORTS  = 2;
    localparam int SADDR_W = $clog2(NUM_REGS * REG_BYTES);
    localparam int CNT_W   = $clog2(REG_BYTES) + 1;

    // Port index 0 and 1 are reads, index 2 is the write port
    logic [NPORT-1:0][REG_W-1:0]   p_reg;
    logic [NPORT-1:0]              p_vec;
    logic [NPORT-1:0][1:0]         p_ew;
    logic [NPORT-1:0][OFF_W-1:0]   p_off;
    logic [NPORT-1:0][SADDR_W-1:0] p_base;
    logic [NPORT-1:0][CNT_W-1:0]   p_cnt;
    logic [NPORT-1:0]              p_oor;
    logic [RPORTS-1:0][DATA_W-1:0] r_data;

    always_comb begin
        p_reg = {wr_reg, rd1_reg, rd0_reg};
        p_vec = {wr_vec, rd1_vec, rd0_vec};
        p_ew  = {wr_ew,  rd1_ew,  rd0_ew};
        p_off = {wr_off, rd1_off, rd0_off};
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_map
        ewrf_addr_map #(
            .NUM_REGS (NUM_REGS),
            .REG_BYTES(REG_BYTES),
            .OFF_W    (OFF_W)
        ) map_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .reg_idx(p_reg[p]),
            .is_vec (p_vec[p]),
            .ew     (ew_e'(p_ew[p])),
            .off    (p_off[p]),
            .base   (p_base[p]),
            .nbytes (p_cnt[p]),
            .oor    (p_oor[p])
        );
    end

    ewrf_byte_store #(
        .NUM_REGS (NUM_REGS),
        .REG_BYTES(REG_BYTES),
        .RD_PORTS (RPORTS)
    ) store_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en && !p_oor[2]),
        .wbase (p_base[2]),
        .wcnt  (p_cnt[2]),
        .wdata (wr_data),
        .rvalid(~p_oor[1:0]),
        .rbase (p_base[1:0]),
        .rcnt  (p_cnt[1:0]),
        .rdata (r_data)
    );

    always_comb begin
        rd0_data = r_data[0];
        rd1_data = r_data[1];
        rd0_oor  = p_oor[0];
        rd1_oor  = p_oor[1];
        wr_oor   = p_oor[2];
    end

    // R7
    rd0_oor_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd0_oor |-> rd0_data == '0);

    // R7
    rd1_oor_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd1_oor |-> rd1_data == '0);

    // R6
    rd0_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0_ew == 2'd0) |-> rd0_data[DATA_W-1:8] == '0);

    // R6
    rd1_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd1_ew == 2'd1) |-> rd1_data[DATA_W-1:16] == '0);

endmodule

// File: tb/ewrf_regfile_tb.sv
module ewrf_regfile_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [6:0]  rd0_reg, rd1_reg, wr_reg;
    logic        rd0_vec, rd1_vec, wr_vec, wr_en;
    logic [1:0]  rd0_ew, rd1_ew, wr_ew;
    logic [9:0]  rd0_off, rd1_off, wr_off;
    logic [63:0] rd0_data, rd1_data, wr_data;
    logic        rd0_oor, rd1_oor, wr_oor;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] mdl [1024];

    always #4 clk = ~clk;

    ewrf_regfile dut_i (
        .clk(clk), .rst_n(rst_n),
        .rd0_reg(rd0_reg), .rd0_vec(rd0_vec), .rd0_ew(rd0_ew), .rd0_off(rd0_off),
        .rd0_data(rd0_data), .rd0_oor(rd0_oor),
        .rd1_reg(rd1_reg), .rd1_vec(rd1_vec), .rd1_ew(rd1_ew), .rd1_off(rd1_off),
        .rd1_data(rd1_data), .rd1_oor(rd1_oor),
        .wr_en(wr_en), .wr_reg(wr_reg), .wr_vec(wr_vec), .wr_ew(wr_ew),
        .wr_off(wr_off), .wr_data(wr_data), .wr_oor(wr_oor)
    );

    function automatic int ref_addr(input int r, input bit v, input int e, input int o);
        return r * 8 + (v ? o : 0) * (1 << e);
    endfunction

    function automatic bit ref_oor(input int r, input bit v, input int e, input int o);
        return (ref_addr(r, v, e, o) + (1 << e) - 1) > 1023;
    endfunction

    function automatic logic [63:0] ref_read(input int r, input bit v, input int e, input int o);
        logic [63:0] res = '0;
        int a = ref_addr(r, v, e, o);
        if (ref_oor(r, v, e, o)) return '0;
        for (int k = 0; k < (1 << e); k++) res[8*k +: 8] = mdl[a + k];
        return res;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic set_rd0(input int r, input bit v, input int e, input int o);
        rd0_reg = 7'(r); rd0_vec = v; rd0_ew = 2'(e); rd0_off = 10'(o);
    endtask

    task automatic set_rd1(input int r, input bit v, input int e, input int o);
        rd1_reg = 7'(r); rd1_vec = v; rd1_ew = 2'(e); rd1_off = 10'(o);
    endtask

    task automatic set_wr(input bit en, input int r, input bit v, input int e,
                          input int o, input logic [63:0] d);
        wr_en = en; wr_reg = 7'(r); wr_vec = v; wr_ew = 2'(e); wr_off = 10'(o); wr_data = d;
    endtask

    // Inputs are already set; check reads mid-cycle, then let the edge commit the write
    task automatic step(input string tag);
        #1;
        chk(tag, rd0_data, ref_read(rd0_reg, rd0_vec, rd0_ew, rd0_off));
        chk(tag, rd1_data, ref_read(rd1_reg, rd1_vec, rd1_ew, rd1_off));
        chk("R7 rd0 flag", 64'(rd0_oor), 64'(ref_oor(rd0_reg, rd0_vec, rd0_ew, rd0_off)));
        chk("R7 rd1 flag", 64'(rd1_oor), 64'(ref_oor(rd1_reg, rd1_vec, rd1_ew, rd1_off)));
        chk("R7 wr flag",  64'(wr_oor),  64'(ref_oor(wr_reg, wr_vec, wr_ew, wr_off)));
        @(posedge clk);
        if (wr_en && !ref_oor(wr_reg, wr_vec, wr_ew, wr_off)) begin
            int a = ref_addr(wr_reg, wr_vec, wr_ew, wr_off);
            for (int k = 0; k < (1 << wr_ew); k++) mdl[a + k] = wr_data[8*k +: 8];
        end
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 1024; i++) mdl[i] = 8'h00;
        rst_n = 1'b0;
        set_rd0(0, 0, 3, 0); set_rd1(127, 0, 3, 0); set_wr(0, 0, 0, 3, 0, '0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset contents
        step("R1 reset regs 0/127");
        set_rd0(64, 1, 0, 5); set_rd1(3, 0, 3, 0);
        step("R1 reset mid store");

        // R5 full scalar write, R8 old value seen in the same cycle
        set_wr(1, 5, 0, 3, 0, 64'h1122_3344_5566_7788);
        set_rd0(5, 0, 3, 0); set_rd1(5, 1, 0, 7);
        step("R8 read during write");
        set_wr(0, 0, 0, 0, 0, '0);
        step("R5 full replace");
        chk("R5 full value", rd0_data, 64'h1122_3344_5566_7788);

        // R4 byte writes to offsets 0..6 keep byte 7
        for (int i = 0; i < 7; i++) begin
            set_wr(1, 5, 1, 0, i, 64'hFFFF_FFFF_FFFF_FFA0 + 64'(i));
            step("R4 byte write");
        end
        set_wr(0, 0, 0, 0, 0, '0);
        step("R4 readback");
        chk("R4 byte7 kept", rd0_data, 64'h11A6_A5A4_A3A2_A1A0);

        // R2 scalar ignores offset on write and read
        set_wr(1, 6, 0, 0, 37, 64'h0000_0000_0000_005A);
        step("R2 scalar write");
        set_wr(0, 0, 0, 0, 0, '0);
        set_rd0(6, 1, 0, 0); set_rd1(6, 0, 0, 999);
        step("R2 scalar read");
        chk("R2 byte at offset 0", rd1_data, 64'h5A);

        // R3 element spilling into following register
        set_wr(1, 10, 1, 1, 5, 64'hDEAD_BEEF_0000_C3B4);
        step("R3 spill write");
        set_wr(0, 0, 0, 0, 0, '0);
        set_rd0(11, 0, 3, 0); set_rd1(10, 0, 3, 0);
        step("R3 spill read");
        chk("R3 in reg 11 bytes 2..3", rd0_data, 64'h0000_0000_C3B4_0000);
        chk("R3 reg 10 untouched", rd1_data, 64'h0);

        // R9 widths: 32-bit write, 16-bit reads of its halves, R6 little-endian
        set_wr(1, 30, 1, 2, 1, 64'h9999_9999_CAFE_F00D);
        step("R9 word write");
        set_wr(0, 0, 0, 0, 0, '0);
        set_rd0(30, 1, 1, 2); set_rd1(30, 1, 1, 3);
        step("R9 half reads");
        chk("R6 low half", rd0_data, 64'hF00D);
        chk("R10 high half on port 1", rd1_data, 64'hCAFE);

        // R7 out of range at top of store
        set_wr(1, 127, 0, 3, 0, 64'h0102_0304_0506_0708);
        step("R7 fill last reg");
        set_wr(1, 127, 1, 2, 2, 64'hFFFF_FFFF_FFFF_FFFF);
        set_rd0(127, 1, 2, 2); set_rd1(127, 1, 2, 1);
        step("R7 oor write/read");
        chk("R7 rd0 flag high", 64'(rd0_oor), 64'd1);
        chk("R7 wr flag high", 64'(wr_oor), 64'd1);
        set_wr(0, 0, 0, 0, 0, '0);
        set_rd0(127, 0, 3, 0);
        step("R7 suppressed write");
        chk("R7 store unchanged", rd0_data, 64'h0102_0304_0506_0708);

        // Random traffic in a small window with occasional large offsets
        for (int n = 0; n < 3000; n++) begin
            bit big = ($urandom % 8) == 0;
            int wr_r = big ? 100 + int'($urandom % 28) : 8 + int'($urandom % 6);
            int wo   = big ? int'($urandom % 1024) : int'($urandom % 12);
            set_wr(($urandom % 4) != 0, wr_r, $urandom % 2, $urandom % 4, wo,
                   {$urandom, $urandom});
            set_rd0(8 + int'($urandom % 6), $urandom % 2, $urandom % 4, $urandom % 12);
            set_rd1(big ? 120 + int'($urandom % 8) : 8 + int'($urandom % 6),
                    $urandom % 2, $urandom % 4, big ? int'($urandom % 64) : int'($urandom % 12));
            step("R6 random");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule